// File: doc/BRIEF.md
# Aligned Byte-Lane Access Checker

This block sits between an effective-address source and a data RAM organised as 32-bit words. Each cycle it may accept one access request made of a byte address, an access size, a read/write flag and write data. It turns a legal request into a RAM word address, a set of per-byte write enables with the write data placed on the right lanes, or a read strobe. One cycle later it returns the addressed bytes right-justified and zero-extended.

Two kinds of request are refused. A misaligned one is a 16-bit access at an odd address, a 32-bit access whose address is not a multiple of four, or the reserved size code. An out-of-range one touches a byte at or beyond the implemented memory size. A refused request drives no write enable and no read strobe. If it is a read, it returns zero. In the same cycle as the request, the block raises a one-cycle address-error trap pulse. Trap handling itself belongs to the surrounding logic.

Top module: `byte_lane_guard`

## Requirements
- R1: reqSize encodes the access width as 2'b00 = 8-bit, 2'b01 = 16-bit, 2'b10 = 32-bit; the code 2'b11 is reserved and always traps with no RAM activity.
- R2: A 16-bit request with reqAddr[0] = 1 traps, asserts no ramWe bit and no ramRe.
- R3: A 32-bit request with reqAddr[1:0] not equal to 2'b00 traps, asserts no ramWe bit and no ramRe.
- R4: A request whose highest addressed byte (reqAddr + width in bytes - 1) is at or above MEM_BYTES traps, writes nothing, and reads back zero.
- R5: trap is combinational with reqValid, is high only in a cycle where reqValid is high and the request is refused, and is low whenever reqValid is low.
- R6: A legal write drives ramAddr = reqAddr >> 2 in the request cycle. It asserts ramWe as 4'b0001 << reqAddr[1:0] for 8-bit, 4'b0011 << reqAddr[1:0] for 16-bit and 4'b1111 for 32-bit. It drives ramWdata = (reqWdata masked to the access width) << (8 * reqAddr[1:0]).
- R7: A legal read asserts ramRe with ramAddr = reqAddr >> 2 in the request cycle. In the next cycle rdValid is high and rdData holds the addressed bytes zero-extended into the low bits, the byte at the lowest address being least significant. rdValid is low in the cycle after any cycle that has no read request.
- R8: A refused read still gives rdValid high in the next cycle, with rdData equal to zero.
- R9: While rstN is low and after its release with no request, rdValid, ramRe and every ramWe bit are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | Access width code (R1) |
| reqAddr | input | ADDR_W | Byte effective address |
| reqWdata | input | 32 | Write data, right-justified |
| trap | output | 1 | Address-error pulse, same cycle as the request |
| ramAddr | output | ADDR_W-2 | RAM word address |
| ramWe | output | 4 | Per-byte write enables |
| ramRe | output | 1 | RAM read strobe |
| ramWdata | output | 32 | Lane-placed write data |
| ramRdata | input | 32 | RAM read word, one cycle after ramRe |
| rdValid | output | 1 | Read result valid |
| rdData | output | 32 | Right-justified, zero-extended read result |

## Verification
The bench builds the block with ADDR_W = 8 and MEM_BYTES = 160. That makes the whole 256-byte address space small enough to sweep at every address, with all four size codes and in both directions. The memory limit is not a power of two, so both sides of the range boundary fall inside the sweep. The first 32-bit word past the edge and the last legal one are hit at every alignment. Two write passes with different data, each followed by a full read pass, compare every legal read against a byte-wise shadow of the memory. This also shows that refused writes left nothing behind.

// File: rtl/lane_guard_pkg.sv
package lane_guard_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned LANE_W = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_FULL = 2'b10,
    SZ_RSVD = 2'b11
  } accSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrGo;       // perform a legal write
    logic rdGo;       // perform a legal read
    logic rdCapture;  // any read request: latch lane and width
    logic rdZero;     // read request was refused
  } laneStrobe_t;

endpackage

// File: rtl/lane_guard_ctrl.sv
module lane_guard_ctrl
  import lane_guard_pkg::*;
#(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned MEM_BYTES = 65536
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  output laneStrobe_t       strobe,
  output logic              trap,
  output logic              rdValid
);

  localparam int unsigned EXT_W = ADDR_W + 1;
  localparam logic [EXT_W-1:0] MEM_LIMIT = EXT_W'(MEM_BYTES);

  accSize_e          sizeCode;
  logic [2:0]        nBytes;
  logic              misAligned;
  logic [EXT_W-1:0]  endAddr;
  logic              outOfRange;
  logic              refused;
  logic              rdValidQ;

  assign sizeCode = accSize_e'(reqSize);

  always_comb begin
    nBytes     = 3'd1;
    misAligned = 1'b0;
    unique case (sizeCode)
      SZ_BYTE: nBytes = 3'd1;
      SZ_HALF: begin
        nBytes     = 3'd2;
        misAligned = reqAddr[0];
      end
      SZ_FULL: begin
        nBytes     = 3'd4;
        misAligned = |reqAddr[1:0];
      end
      default: begin
        nBytes     = 3'd1;
        misAligned = 1'b1;
      end
    endcase
  end

  // one past the highest touched byte; compare against the implemented size
  assign endAddr    = {1'b0, reqAddr} + EXT_W'(nBytes);
  assign outOfRange = endAddr > MEM_LIMIT;
  assign refused    = misAligned | outOfRange;

  assign trap = reqValid & refused;

  always_comb begin
    strobe           = '0;
    strobe.wrGo      = reqValid & reqWrite & ~refused;
    strobe.rdGo      = reqValid & ~reqWrite & ~refused;
    strobe.rdCapture = reqValid & ~reqWrite;
    strobe.rdZero    = reqValid & ~reqWrite & refused;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValidQ <= 1'b0;
    end else begin
      rdValidQ <= strobe.rdCapture;
    end
  end

  assign rdValid = rdValidQ;

endmodule

// File: rtl/lane_guard_dp.sv
module lane_guard_dp
  import lane_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  laneStrobe_t       strobe,
  input  logic [1:0]        reqSize,
  input  logic [LANE_W-1:0] laneOfs,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] ramRdata,
  output logic [LANES-1:0]  ramWe,
  output logic              ramRe,
  output logic [DATA_W-1:0] ramWdata,
  output logic [DATA_W-1:0] rdData
);

  accSize_e          sizeCode;
  logic [DATA_W-1:0] wrMasked;
  logic [LANES-1:0]  laneHit;

  accSize_e          sizeQ;
  logic [LANE_W-1:0] ofsQ;
  logic              zeroQ;
  logic [DATA_W-1:0] rdShifted;

  assign sizeCode = accSize_e'(reqSize);

  // per-lane enable decode
  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    localparam logic [LANE_W-1:0] LANE_ID = LANE_W'(lane);
    always_comb begin
      unique case (sizeCode)
        SZ_BYTE: laneHit[lane] = (laneOfs == LANE_ID);
        SZ_HALF: laneHit[lane] = (laneOfs[LANE_W-1] == LANE_ID[LANE_W-1]);
        SZ_FULL: laneHit[lane] = 1'b1;
        default: laneHit[lane] = 1'b0;
      endcase
    end
  end

  assign ramWe = strobe.wrGo ? laneHit : '0;
  assign ramRe = strobe.rdGo;

  always_comb begin
    unique case (sizeCode)
      SZ_BYTE: wrMasked = {{(DATA_W-8){1'b0}},  reqWdata[7:0]};
      SZ_HALF: wrMasked = {{(DATA_W-16){1'b0}}, reqWdata[15:0]};
      default: wrMasked = reqWdata;
    endcase
  end

  assign ramWdata = wrMasked << {laneOfs, 3'b000};

  // read return: remember lane, width and refusal for the data cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sizeQ <= SZ_BYTE;
      ofsQ  <= '0;
      zeroQ <= 1'b1;
    end else if (strobe.rdCapture) begin
      sizeQ <= sizeCode;
      ofsQ  <= laneOfs;
      zeroQ <= strobe.rdZero;
    end
  end

  assign rdShifted = ramRdata >> {ofsQ, 3'b000};

  always_comb begin
    if (zeroQ) begin
      rdData = '0;
    end else begin
      unique case (sizeQ)
        SZ_BYTE: rdData = {{(DATA_W-8){1'b0}},  rdShifted[7:0]};
        SZ_HALF: rdData = {{(DATA_W-16){1'b0}}, rdShifted[15:0]};
        default: rdData = rdShifted;
      endcase
    end
  end

endmodule

// File: rtl/byte_lane_guard.sv
module byte_lane_guard
  import lane_guard_pkg::*;
#(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned MEM_BYTES = 65536
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic              trap,
  output logic [ADDR_W-3:0] ramAddr,
  output logic [3:0]        ramWe,
  output logic              ramRe,
  output logic [31:0]       ramWdata,
  input  logic [31:0]       ramRdata,
  output logic              rdValid,
  output logic [31:0]       rdData
);

  laneStrobe_t strobe;

  assign ramAddr = reqAddr[ADDR_W-1:LANE_W];

  lane_guard_ctrl #(
    .ADDR_W   (ADDR_W),
    .MEM_BYTES(MEM_BYTES)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqSize (reqSize),
    .reqAddr (reqAddr),
    .strobe  (strobe),
    .trap    (trap),
    .rdValid (rdValid)
  );

  lane_guard_dp dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqSize (reqSize),
    .laneOfs (reqAddr[LANE_W-1:0]),
    .reqWdata(reqWdata),
    .ramRdata(ramRdata),
    .ramWe   (ramWe),
    .ramRe   (ramRe),
    .ramWdata(ramWdata),
    .rdData  (rdData)
  );

endmodule

// File: rtl/byte_lane_guard_chk.sv
module byte_lane_guard_chk #(
  parameter int unsigned ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [1:0]        reqSize,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              trap,
  input logic [3:0]        ramWe,
  input logic              ramRe,
  input logic              rdValid,
  input logic [31:0]       rdData
);

  a_r1_reserved_traps: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqSize == 2'b11 |-> trap && ramWe == 4'b0 && !ramRe);

  a_r2_odd_half_traps: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqSize == 2'b01 && reqAddr[0] |-> trap && ramWe == 4'b0 && !ramRe);

  a_r3_unaligned_full_traps: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqSize == 2'b10 && reqAddr[1:0] != 2'b00 |-> trap && ramWe == 4'b0 && !ramRe);

  a_r4_trap_is_quiet: assert property (@(posedge clk) disable iff (!rstN)
    trap |-> ramWe == 4'b0 && !ramRe);

  a_r5_no_trap_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> !trap && ramWe == 4'b0 && !ramRe);

  a_r6_lane_count: assert property (@(posedge clk) disable iff (!rstN)
    $countones(ramWe) == 0 || $countones(ramWe) == 1 ||
    $countones(ramWe) == 2 || $countones(ramWe) == 4);

  a_r7_read_returns: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqWrite |=> rdValid);

  a_r7_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && !reqWrite) |=> !rdValid);

  a_r8_refused_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqWrite && trap |=> rdValid && rdData == 32'b0);

endmodule

bind byte_lane_guard byte_lane_guard_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .reqWrite(reqWrite),
  .reqSize (reqSize),
  .reqAddr (reqAddr),
  .trap    (trap),
  .ramWe   (ramWe),
  .ramRe   (ramRe),
  .rdValid (rdValid),
  .rdData  (rdData)
);

// File: tb/byte_lane_guard_tb_top.sv
`timescale 1ns/1ps
module byte_lane_guard_tb_top;

  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned MEM_BYTES = 160;
  localparam int unsigned SPACE     = 1 << ADDR_W;
  localparam int unsigned WORDS     = SPACE / 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqWrite = 1'b0;
  logic [1:0]        reqSize = 2'b00;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [31:0]       reqWdata = '0;
  logic              trap;
  logic [ADDR_W-3:0] ramAddr;
  logic [3:0]        ramWe;
  logic              ramRe;
  logic [31:0]       ramWdata;
  logic [31:0]       ramRdata = '0;
  logic              rdValid;
  logic [31:0]       rdData;

  int vecCnt  = 0;
  int missCnt = 0;
  bit finished = 1'b0;

  logic [31:0] ramModel [WORDS];
  logic [7:0]  shadow   [MEM_BYTES];

  always #10 clk = ~clk;  // 50 MHz

  byte_lane_guard #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqAddr(reqAddr), .reqWdata(reqWdata), .trap(trap),
    .ramAddr(ramAddr), .ramWe(ramWe), .ramRe(ramRe), .ramWdata(ramWdata),
    .ramRdata(ramRdata), .rdValid(rdValid), .rdData(rdData)
  );

  // simple word RAM with byte enables and one-cycle read
  always_ff @(posedge clk) begin
    for (int b = 0; b < 4; b++) begin
      if (ramWe[b]) ramModel[ramAddr][8*b +: 8] <= ramWdata[8*b +: 8];
    end
    if (ramRe) ramRdata <= ramModel[ramAddr];
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vecCnt++;
    if (act !== exp) begin
      missCnt++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pattern(input int a, input int s, input int pass);
    return {8'(a * 7 + s), 8'(a ^ 8'h5A), 8'(a + pass * 13), 8'(~a)};
  endfunction

  task automatic access(input int a, input int s, input bit wr, input logic [31:0] wd);
    int          nb;
    bit          mis;
    bit          oor;
    bit          refuse;
    logic [3:0]  expWe;
    logic [31:0] expWd;
    logic [31:0] expRd;
    string       tag;
    nb  = (s == 0) ? 1 : (s == 1) ? 2 : 4;
    mis = (s == 3) || (s == 1 && a[0]) || (s == 2 && a[1:0] != 2'b00);
    oor = (a + nb) > MEM_BYTES;
    refuse = mis || oor;
    if (s == 3)      tag = "R1";
    else if (s == 1 && a[0]) tag = "R2";
    else if (s == 2 && a[1:0] != 2'b00) tag = "R3";
    else if (oor)    tag = "R4";
    else             tag = "R5";

    expWe = 4'b0000;
    expWd = 32'b0;
    if (wr && !refuse) begin
      case (s)
        0: begin expWe = 4'b0001 << a[1:0]; expWd = (wd & 32'h0000_00FF) << (8 * a[1:0]); end
        1: begin expWe = 4'b0011 << a[1:0]; expWd = (wd & 32'h0000_FFFF) << (8 * a[1:0]); end
        default: begin expWe = 4'b1111; expWd = wd; end
      endcase
    end
    expRd = 32'b0;
    if (!wr && !refuse) begin
      for (int k = 0; k < nb; k++) expRd[8*k +: 8] = shadow[a + k];
    end

    @(negedge clk);
    reqValid = 1'b1;
    reqWrite = wr;
    reqSize  = 2'(s);
    reqAddr  = ADDR_W'(a);
    reqWdata = wd;
    #2;
    chk(tag, "trap", 32'(trap), 32'(refuse));
    chk(refuse ? tag : "R6", "ramWe", 32'(ramWe), 32'(expWe));
    chk(refuse ? tag : "R7", "ramRe", 32'(ramRe), 32'(!wr && !refuse));
    if (!refuse) chk(wr ? "R6" : "R7", "ramAddr", 32'(ramAddr), 32'(a >> 2));
    if (expWe != 4'b0) chk("R6", "ramWdata", ramWdata, expWd);
    if (wr && !refuse) begin
      for (int k = 0; k < nb; k++) shadow[a + k] = expWd[8*(a[1:0] + k) +: 8];
    end

    @(negedge clk);
    reqValid = 1'b0;
    #2;
    chk("R5", "idle trap", 32'(trap), 32'b0);
    chk("R7", "rdValid", 32'(rdValid), 32'(!wr));
    if (!wr) chk(refuse ? "R8" : "R7", "rdData", rdData, expRd);
  endtask

  initial begin
    for (int w = 0; w < WORDS; w++) ramModel[w] = 32'b0;
    for (int b = 0; b < MEM_BYTES; b++) shadow[b] = 8'b0;

    // R9: reset state
    repeat (3) @(negedge clk);
    #2;
    chk("R9", "rdValid in reset", 32'(rdValid), 32'b0);
    chk("R9", "ramWe in reset", 32'(ramWe), 32'b0);
    chk("R9", "ramRe in reset", 32'(ramRe), 32'b0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #2;
    chk("R9", "rdValid after reset", 32'(rdValid), 32'b0);
    chk("R9", "ramWe after reset", 32'(ramWe), 32'b0);
    chk("R9", "trap after reset", 32'(trap), 32'b0);

    for (int pass = 0; pass < 2; pass++) begin
      for (int a = 0; a < SPACE; a++) begin
        for (int s = 0; s < 4; s++) begin
          access(a, s, 1'b1, pattern(a, s, pass));
        end
      end
      for (int a = 0; a < SPACE; a++) begin
        for (int s = 0; s < 4; s++) begin
          access(a, s, 1'b0, 32'hDEAD_BEEF);
        end
      end
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      vecCnt++;
      missCnt++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
      $finish;
    end
  end

endmodule